// File: doc/BRIEF.md
# CPU Power-Down Mode Controller

This block holds the power-down and interrupt-enable fields of a 32-bit processor control/status register and turns the power-down field into clock-enable outputs for two domains: the processor core and the peripherals. Software writes a mode code into the field. While the core clock is enabled, that write takes effect at the next clock edge. From then on the controller keeps the selected clocks off until a wake condition occurs.

There are two light modes and two deep modes. The light modes stop only the core clock. One light mode wakes on an interrupt line that is both pending and unmasked. The other wakes on any pending line, masked or not. The deep modes also stop the peripheral clock, and only reset leaves them. When a light mode wakes, the field returns to zero in the same cycle that the core clock enable comes back. The reference clocks stay enabled at all times. The actual gating cells and the PLL sit outside this block.

The reset input is asynchronous and active low. The block releases it to its registers through an internal two-stage synchronizer.

Top module: `cpu_pwrdn_ctrl`

## Requirements
- R1: While reset is applied, and after it, the register reads 0x0000_0000, pd_mode is 0 and core_clk_en and periph_clk_en are both 1.
- R2: A write accepted while pd_mode is 0 stores csr_wdata[15:10] as the power-down field, bit 1 as the previous-enable bit and bit 0 as the global-enable bit. Every other bit of csr_rdata reads 0. The new value is visible one clock edge after the write.
- R3: Field code 6'b001001 gives pd_mode 1 with core_clk_en 0 and periph_clk_en 1. The block stays in this mode while no line has both irq_req and irq_en set.
- R4: Field code 6'b010001 gives pd_mode 2 with core_clk_en 0 and periph_clk_en 1. Any set irq_req bit wakes it, whatever irq_en holds.
- R5: On a wake from pd_mode 1 or 2, the next edge clears the field to 6'b000000 and raises core_clk_en, and pd_mode returns to 0. The global-enable and previous-enable bits keep their values. Wake does not depend on the global-enable bit.
- R6: Field code 6'b011010 gives pd_mode 3 and code 6'b011100 gives pd_mode 4. Both clear core_clk_en and periph_clk_en. Interrupt lines have no effect in these modes, and only reset leaves them.
- R7: Any other nonzero field value is stored and reads back as written, but it counts as no power-down: pd_mode stays 0 and both clock enables stay 1.
- R8: A write attempted while pd_mode is not 0 is ignored and leaves csr_rdata unchanged.
- R9: refclk_en is 1 at all times, including during reset and in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the control/status register |
| csr_wdata | input | 32 | Write data for the control/status register |
| csr_rdata | output | 32 | Current value of the stored register fields |
| irq_req | input | IRQ_W (12) | Pending interrupt lines |
| irq_en | input | IRQ_W (12) | Interrupt mask, 1 = enabled |
| core_clk_en | output | 1 | Clock enable for the core domain |
| periph_clk_en | output | 1 | Clock enable for the peripheral domain |
| refclk_en | output | 1 | Enable for the input and divided reference clocks |
| pd_mode | output | 3 | Active mode: 0 run, 1 light/enabled wake, 2 light/any wake, 3 and 4 deep |

## Verification
Every result, whether from a write or from a wake, is due one rising edge after the inputs are presented. The inputs are driven on the falling edge, and the outputs are compared with a bench model on the next falling edge, half a period after the edge that makes them due. When rst_n is released, the synchronizer delays the first functional edge by two edges. The bench therefore holds the inputs idle for three cycles before it drives any stimulus. Within a deep mode, the bench presents interrupts and writes for several cycles and checks that nothing moves until the next reset.

// File: rtl/cpu_pwrdn_pkg.sv
package cpu_pwrdn_pkg;

  localparam int unsigned CSR_W    = 32;
  localparam int unsigned PD_LSB   = 10;
  localparam int unsigned PD_W     = 6;
  localparam int unsigned GIE_POS  = 0;
  localparam int unsigned PGIE_POS = 1;

  localparam logic [PD_W-1:0] PD_CODE_NONE     = 6'b000000;
  localparam logic [PD_W-1:0] PD_CODE_LITE_EN  = 6'b001001;
  localparam logic [PD_W-1:0] PD_CODE_LITE_ANY = 6'b010001;
  localparam logic [PD_W-1:0] PD_CODE_DEEP2    = 6'b011010;
  localparam logic [PD_W-1:0] PD_CODE_DEEP3    = 6'b011100;

  typedef enum logic [2:0] {
    PDM_RUN      = 3'd0,
    PDM_LITE_EN  = 3'd1,
    PDM_LITE_ANY = 3'd2,
    PDM_DEEP2    = 3'd3,
    PDM_DEEP3    = 3'd4
  } pd_mode_e;

  // Reserved codes fall back to run
  function automatic pd_mode_e pd_decode(input logic [PD_W-1:0] field);
    pd_mode_e m;
    case (field)
      PD_CODE_LITE_EN:  m = PDM_LITE_EN;
      PD_CODE_LITE_ANY: m = PDM_LITE_ANY;
      PD_CODE_DEEP2:    m = PDM_DEEP2;
      PD_CODE_DEEP3:    m = PDM_DEEP3;
      default:          m = PDM_RUN;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cpu_pwrdn_rst_sync.sv
module cpu_pwrdn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cpu_pwrdn_csr.sv
module cpu_pwrdn_csr
  import cpu_pwrdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             wr_allow,
  input  logic             wake,
  output logic [PD_W-1:0]  pd_field,
  output logic [CSR_W-1:0] rd_data
);

  logic [PD_W-1:0] pd_q, pd_d;
  logic            gie_q, gie_d;
  logic            pgie_q, pgie_d;
  logic            wr_take;
  logic            ld_en;
  logic            unused_wbits;

  assign unused_wbits = ^{wr_data[CSR_W-1:PD_LSB+PD_W], wr_data[PD_LSB-1:PGIE_POS+1]};

  assign wr_take = wr_en & wr_allow;
  assign ld_en   = wake | wr_take;

  // Wake has priority; the core cannot issue a write while stopped
  always_comb begin
    pd_d   = pd_q;
    gie_d  = gie_q;
    pgie_d = pgie_q;
    if (wake) begin
      pd_d = PD_CODE_NONE;
    end else if (wr_take) begin
      pd_d   = wr_data[PD_LSB +: PD_W];
      gie_d  = wr_data[GIE_POS];
      pgie_d = wr_data[PGIE_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= PD_CODE_NONE;
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else if (ld_en) begin
      pd_q   <= pd_d;
      gie_q  <= gie_d;
      pgie_q <= pgie_d;
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[PD_LSB +: PD_W]   = pd_q;
    rd_data[GIE_POS]          = gie_q;
    rd_data[PGIE_POS]         = pgie_q;
  end

  assign pd_field = pd_q;

endmodule

// File: rtl/cpu_pwrdn_mode_dec.sv
module cpu_pwrdn_mode_dec
  import cpu_pwrdn_pkg::*;
(
  input  logic [PD_W-1:0] pd_field,
  output pd_mode_e        mode,
  output logic            core_en,
  output logic            periph_en,
  output logic            wr_allow
);

  logic deep;

  always_comb begin
    mode      = pd_decode(pd_field);
    deep      = (mode == PDM_DEEP2) || (mode == PDM_DEEP3);
    core_en   = (mode == PDM_RUN);
    periph_en = !deep;
    wr_allow  = (mode == PDM_RUN);
  end

endmodule

// File: rtl/cpu_pwrdn_wake.sv
module cpu_pwrdn_wake
  import cpu_pwrdn_pkg::*;
#(
  parameter int unsigned IRQ_W = 12
) (
  input  pd_mode_e         mode,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             wake
);

  logic [IRQ_W-1:0] hit_masked;
  logic             any_masked;
  logic             any_raw;

  generate
    for (genvar i = 0; i < IRQ_W; i++) begin : g_line
      assign hit_masked[i] = irq_req[i] & irq_en[i];
    end
  endgenerate

  assign any_masked = |hit_masked;
  assign any_raw    = |irq_req;

  // Deep modes have no interrupt wake path
  always_comb begin
    case (mode)
      PDM_LITE_EN:  wake = any_masked;
      PDM_LITE_ANY: wake = any_raw;
      default:      wake = 1'b0;
    endcase
  end

endmodule

// File: rtl/cpu_pwrdn_ctrl.sv
module cpu_pwrdn_ctrl
  import cpu_pwrdn_pkg::*;
#(
  parameter int unsigned IRQ_W     = 12,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             refclk_en,
  output logic [2:0]       pd_mode
);

  logic            rst_core_n;
  logic [PD_W-1:0] pd_field;
  pd_mode_e        mode;
  logic            wr_allow;
  logic            wake;

  cpu_pwrdn_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cpu_pwrdn_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (csr_we),
    .wr_data  (csr_wdata),
    .wr_allow (wr_allow),
    .wake     (wake),
    .pd_field (pd_field),
    .rd_data  (csr_rdata)
  );

  cpu_pwrdn_mode_dec u_dec (
    .pd_field  (pd_field),
    .mode      (mode),
    .core_en   (core_clk_en),
    .periph_en (periph_clk_en),
    .wr_allow  (wr_allow)
  );

  cpu_pwrdn_wake #(.IRQ_W(IRQ_W)) u_wake (
    .mode    (mode),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .wake    (wake)
  );

  assign pd_mode   = mode;
  assign refclk_en = 1'b1;

endmodule

// File: rtl/cpu_pwrdn_ctrl_chk.sv
module cpu_pwrdn_ctrl_chk
  import cpu_pwrdn_pkg::*;
#(
  parameter int unsigned IRQ_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [31:0]      csr_wdata,
  input logic [31:0]      csr_rdata,
  input logic [IRQ_W-1:0] irq_req,
  input logic [IRQ_W-1:0] irq_en,
  input logic             core_clk_en,
  input logic             periph_clk_en,
  input logic [2:0]       pd_mode
);

  // R3
  lite_en_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && pd_mode == 3'd0 && csr_wdata[PD_LSB +: PD_W] == PD_CODE_LITE_EN)
    |=> (pd_mode == 3'd1 && !core_clk_en && periph_clk_en));

  // R3
  lite_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 3'd1 && !(|(irq_req & irq_en))) |=> (pd_mode == 3'd1));

  // R5
  wake_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 3'd1 && |(irq_req & irq_en))
    |=> (pd_mode == 3'd0 && core_clk_en && csr_rdata[PD_LSB +: PD_W] == PD_CODE_NONE));

  // R4
  wake_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 3'd2 && |irq_req) |=> (pd_mode == 3'd0 && core_clk_en));

  // R6
  deep_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 3'd3 || pd_mode == 3'd4)
    |=> ($stable(pd_mode) && !core_clk_en && !periph_clk_en));

  // R8
  deep_ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_mode == 3'd3 || pd_mode == 3'd4) && csr_we) |=> $stable(csr_rdata));

  // R6
  periph_off_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> !core_clk_en);

endmodule

bind cpu_pwrdn_ctrl cpu_pwrdn_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .csr_we        (csr_we),
  .csr_wdata     (csr_wdata),
  .csr_rdata     (csr_rdata),
  .irq_req       (irq_req),
  .irq_en        (irq_en),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pd_mode       (pd_mode)
);

// File: tb/test_cpu_pwrdn_ctrl.sv
`timescale 1ns/1ps
module test_cpu_pwrdn_ctrl;

  localparam int IRQ_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             csr_we;
  logic [31:0]      csr_wdata;
  logic [31:0]      csr_rdata;
  logic [IRQ_W-1:0] irq_req;
  logic [IRQ_W-1:0] irq_en;
  logic             core_clk_en;
  logic             periph_clk_en;
  logic             refclk_en;
  logic [2:0]       pd_mode;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic [5:0] m_pd;
  logic       m_gie;
  logic       m_pgie;

  always #10 clk = ~clk;

  cpu_pwrdn_ctrl #(.IRQ_W(IRQ_W)) i_cpu_pwrdn_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_we        (csr_we),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .refclk_en     (refclk_en),
    .pd_mode       (pd_mode)
  );

  // mode numbering from R3, R4, R6, R7
  function automatic logic [2:0] exp_mode(input logic [5:0] f);
    case (f)
      6'b001001: return 3'd1;
      6'b010001: return 3'd2;
      6'b011010: return 3'd3;
      6'b011100: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [5:0] f, input logic pg, input logic g);
    return {16'h0, f, 8'h00, pg, g};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [2:0] em;
    em = exp_mode(m_pd);
    chk("R2 rdata", csr_rdata, exp_rdata(m_pd, m_pgie, m_gie));
    chk("R3 mode", {29'h0, pd_mode}, {29'h0, em});
    chk("R5 core_en", {31'h0, core_clk_en}, {31'h0, em == 3'd0});
    chk("R6 periph_en", {31'h0, periph_clk_en}, {31'h0, !(em == 3'd3 || em == 3'd4)});
    chk("R9 refclk_en", {31'h0, refclk_en}, 32'h1);
  endtask

  // one functional cycle: drive at falling edge, model at rising, compare at next falling
  task automatic step(input logic we, input logic [31:0] wd,
                      input logic [IRQ_W-1:0] rq, input logic [IRQ_W-1:0] en);
    logic [2:0] mm;
    logic       wk;
    csr_we = we; csr_wdata = wd; irq_req = rq; irq_en = en;
    @(posedge clk);
    mm = exp_mode(m_pd);
    wk = (mm == 3'd1 && |(rq & en)) || (mm == 3'd2 && |rq);
    if (wk) m_pd = 6'b000000;
    else if (we && mm == 3'd0) begin
      m_pd = wd[15:10]; m_pgie = wd[1]; m_gie = wd[0];
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset(input bit check_during);
    csr_we = 1'b0; csr_wdata = '0; irq_req = '0; irq_en = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_pd = '0; m_gie = 1'b0; m_pgie = 1'b0;
    if (check_during) begin
      // R1 during reset, R9 during reset
      chk("R1 rdata in reset", csr_rdata, 32'h0);
      chk("R9 refclk in reset", {31'h0, refclk_en}, 32'h1);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] wcode(input logic [5:0] c, input logic [31:0] base);
    logic [31:0] w;
    w = base;
    w[15:10] = c;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9BDF));
    @(negedge clk);
    do_reset(1'b1);

    // R1 after reset
    chk("R1 rdata", csr_rdata, 32'h0);
    chk("R1 mode", {29'h0, pd_mode}, 32'h0);
    chk("R1 core_en", {31'h0, core_clk_en}, 32'h1);
    chk("R1 periph_en", {31'h0, periph_clk_en}, 32'h1);

    // R2 and R7: reserved code with all bits set
    step(1'b1, 32'hFFFF_FFFF, '0, '0);
    chk("R2 field map", csr_rdata, 32'h0000_FC03);
    chk("R7 reserved run", {29'h0, pd_mode, core_clk_en, periph_clk_en} , {29'h0, 3'd0, 2'b11});

    // R3 entry and hold
    step(1'b1, wcode(6'b001001, 32'h1), '0, '0);
    chk("R3 entry", {27'h0, pd_mode, core_clk_en, periph_clk_en}, {27'h0, 3'd1, 2'b01});
    step(1'b0, '0, 12'h0F0, 12'h00F);
    chk("R3 masked irq holds", {29'h0, pd_mode}, 32'h1);
    // R8 write in light mode ignored
    step(1'b1, 32'h0000_0002, '0, '0);
    chk("R8 light write ignored", csr_rdata, 32'h0000_2401);
    // R5 wake by enabled line, GIE kept
    step(1'b0, '0, 12'h010, 12'h010);
    chk("R5 wake clears field", csr_rdata, 32'h0000_0001);
    chk("R5 core back", {31'h0, core_clk_en}, 32'h1);

    // R4 any-interrupt wake ignores mask
    step(1'b1, wcode(6'b010001, 32'h2), '0, '0);
    chk("R4 entry", {29'h0, pd_mode}, 32'h2);
    step(1'b0, '0, 12'h800, 12'h000);
    chk("R4 unmasked-free wake", {29'h0, pd_mode}, 32'h0);
    chk("R5 PGIE kept", csr_rdata, 32'h0000_0002);

    // R6 deep mode 3
    step(1'b1, wcode(6'b011010, 32'h0), '0, '0);
    chk("R6 deep2 entry", {27'h0, pd_mode, core_clk_en, periph_clk_en}, {27'h0, 3'd3, 2'b00});
    for (int k = 0; k < 5; k++) step(1'b1, 32'h0, 12'hFFF, 12'hFFF);
    chk("R6 deep2 stuck", {29'h0, pd_mode}, 32'h3);
    chk("R8 deep write ignored", csr_rdata, 32'h0000_6800);
    do_reset(1'b1);
    chk("R1 deep exit by reset", {29'h0, pd_mode}, 32'h0);

    // R6 deep mode 4
    step(1'b1, wcode(6'b011100, 32'h0), '0, '0);
    chk("R6 deep3 entry", {27'h0, pd_mode, core_clk_en, periph_clk_en}, {27'h0, 3'd4, 2'b00});
    for (int k = 0; k < 4; k++) step(1'b0, '0, 12'hFFF, 12'h000);
    chk("R6 deep3 stuck", {29'h0, pd_mode}, 32'h4);
    do_reset(1'b0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [5:0]       c;
      logic [31:0]      w;
      logic [IRQ_W-1:0] rq;
      logic [IRQ_W-1:0] en;
      logic             we;
      logic [2:0]       mm;
      mm = exp_mode(m_pd);
      if ((mm == 3'd3 || mm == 3'd4) && ($urandom % 12 == 0)) begin
        do_reset(1'b0);
        check_all();
      end
      case ($urandom % 8)
        0: c = 6'b000000;
        1: c = 6'b001001;
        2: c = 6'b010001;
        3: c = ($urandom % 4 == 0) ? 6'b011010 : 6'b001001;
        4: c = ($urandom % 4 == 0) ? 6'b011100 : 6'b010001;
        default: c = 6'($urandom);
      endcase
      w  = wcode(c, $urandom);
      we = ($urandom % 3 == 0);
      rq = IRQ_W'($urandom & $urandom & $urandom);
      en = IRQ_W'($urandom);
      step(we, w, rq, en);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule